// File: doc/BRIEF.md
# Partial-Register Write Merge Tracker

This block is an eight-entry architectural register file of 64-bit registers. Each write carries a size code. A full write or a low-word write replaces the whole register, and a low-word write clears the upper half to zero. A write to one of the two lowest bytes goes into a shadow slot that belongs to that byte. The register's other bits and its other byte slot stay unchanged, so writes to the two bytes never wait on each other.

For every register the block records whether either byte slot holds data that has not yet been folded into the base value. Reading a single byte costs nothing, because the byte comes from its slot or from the base. A 32-bit or 64-bit read of a register with dirty slots must first fold the slots into the base. While it does this the block raises `stall` for a fixed number of cycles. It then writes the merged value back, so the register is no longer split, and presents the data. While the merge runs, a write to the register being merged is refused. A write to any other register goes ahead.

Top module: `prw_merge_tracker`

## Requirements
- R1: A write with size 2'b11 replaces all 64 bits of the register, and a read with size 2'b11 returns all 64 bits.
- R2: A write with size 2'b10 puts wrData[31:0] into bits 31:0 and clears bits 63:32. A read with size 2'b10 returns bits 31:0 with rdData[63:32] zero.
- R3: A write with size 2'b00 changes only bits 7:0 of the register, and size 2'b01 changes only bits 15:8. Both take the byte from wrData[7:0]. Writes to the two bytes in consecutive cycles both take effect.
- R4: A byte read (size 2'b00 for bits 7:0, 2'b01 for bits 15:8) returns the byte in rdData[7:0] with the upper bits zero. rdValid is high in the cycle after the request, and stall stays low, whether or not the byte slots are dirty.
- R5: A wide read (size 2'b10 or 2'b11) of a register with a dirty byte slot holds stall high for exactly MERGE_CYCLES cycles, starting in the cycle after the request. rdValid and the merged data appear in the first cycle after stall falls.
- R6: After a merge the register is no longer split, so another wide read of it gives rdValid in the next cycle with no stall.
- R7: A 32-bit or 64-bit write that follows byte writes clears the split state, so a later wide read does not stall.
- R8: While stall is high, a write to the register being merged is dropped, and a write to any other register is applied.
- R9: A read request made while stall is high is ignored and produces no rdValid pulse.
- R10: After reset every register reads as zero with no split state, and stall and rdValid are low. A wide read of a register that is not split gives rdValid in the next cycle with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Write request |
| wrAddr | input | 3 | Register written |
| wrSize | input | 2 | Write size code |
| wrData | input | 64 | Write data |
| rdReq | input | 1 | Read request |
| rdAddr | input | 3 | Register read |
| rdSize | input | 2 | Read size code |
| rdData | output | 64 | Read data, meaningful while rdValid is high |
| rdValid | output | 1 | Read data valid |
| stall | output | 1 | Merge in progress |

## Verification
The bench counts the exact stall length of a wide read on a split register. A control block with an off-by-one counter would show one stall cycle too many or too few, or would raise rdValid while still stalled. It reads bytes from dirty registers and expects no stall, which catches a design that merges on every read. It checks that the upper half is cleared after a low-word write and that a byte write leaves the neighbouring byte alone. It drives a write to the register under merge and a write to another register during the stall, plus a stray read. A design that fails to block the first write would return or store the wrong value, one that blocks every write would lose the second, and one that accepts the stray read would produce an extra valid pulse.

// File: rtl/prw_pkg.sv
package prw_pkg;

  typedef enum logic [1:0] {
    SZ_LOW_BYTE    = 2'b00,
    SZ_SECOND_BYTE = 2'b01,
    SZ_LOW_WORD    = 2'b10,
    SZ_FULL        = 2'b11
  } accessSize_e;

  typedef struct packed {
    logic wrAccept;
    logic readNow;
    logic mergeCommit;
  } ctlStrobes_t;

  function automatic logic isWide(input logic [1:0] sizeCode);
    return sizeCode[1];
  endfunction

endpackage

// File: rtl/prw_control.sv
module prw_control
  import prw_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int MERGE_CYCLES = 2,
  localparam int ADDR_W      = $clog2(NUM_REGS),
  localparam int CNT_W       = $clog2(MERGE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              needsMerge,
  output ctlStrobes_t       strobes,
  output logic [ADDR_W-1:0] commitAddr,
  output logic [1:0]        commitSize,
  output logic              stall,
  output logic              rdValid
);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] lockAddr;
  logic [1:0]        lockSize;
  logic              startMerge;
  logic              reqAccepted;

  assign reqAccepted = rdReq && !busy;
  assign startMerge  = reqAccepted && isWide(rdSize) && needsMerge;

  always_comb begin
    strobes.readNow     = reqAccepted && !(isWide(rdSize) && needsMerge);
    strobes.mergeCommit = busy && (cnt == '0);
    strobes.wrAccept    = wrEn && !(busy && (wrAddr == lockAddr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cnt      <= '0;
      lockAddr <= '0;
      lockSize <= '0;
      rdValid  <= 1'b0;
    end else begin
      rdValid <= strobes.readNow || strobes.mergeCommit;
      if (startMerge) begin
        busy     <= 1'b1;
        cnt      <= CNT_W'(MERGE_CYCLES - 1);
        lockAddr <= rdAddr;
        lockSize <= rdSize;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign stall      = busy;
  assign commitAddr = lockAddr;
  assign commitSize = lockSize;

  // Independent run-length counter used only by the checks below.
  logic [CNT_W:0] stallRun;
  always_ff @(posedge clk) begin
    if (rst)        stallRun <= '0;
    else if (stall) stallRun <= stallRun + 1'b1;
    else            stallRun <= '0;
  end

  AST_STALL_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    stall |-> (stallRun < (CNT_W+1)'(MERGE_CYCLES))); // R5
  AST_STALL_FULL_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> ($past(stallRun) == (CNT_W+1)'(MERGE_CYCLES - 1))); // R5
  AST_VALID_AFTER_STALL: assert property (@(posedge clk) disable iff (rst)
    $fell(stall) |-> rdValid); // R5
  AST_NO_VALID_WHILE_STALL: assert property (@(posedge clk) disable iff (rst)
    stall |-> !rdValid); // R9
  AST_BYTE_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (rdReq && !stall && !isWide(rdSize)) |=> (!stall && rdValid)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!stall && !rdValid)); // R10

endmodule

// File: rtl/prw_datapath.sv
module prw_datapath
  import prw_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 64,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int BYTE_W  = 8,
  localparam int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       strobes,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  input  logic [ADDR_W-1:0] commitAddr,
  input  logic [1:0]        commitSize,
  output logic              needsMerge,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] baseReg   [NUM_REGS];
  logic [BYTE_W-1:0] lowSlot   [NUM_REGS];
  logic [BYTE_W-1:0] highSlot  [NUM_REGS];
  logic [NUM_REGS-1:0] lowDirty;
  logic [NUM_REGS-1:0] highDirty;
  logic [DATA_W-1:0] mergedView [NUM_REGS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_REGS; gi++) begin : gEntry
      logic hitWrite;
      logic hitCommit;
      assign hitWrite  = strobes.wrAccept && (wrAddr == ADDR_W'(gi));
      assign hitCommit = strobes.mergeCommit && (commitAddr == ADDR_W'(gi));

      always_comb begin
        mergedView[gi] = baseReg[gi];
        if (lowDirty[gi])  mergedView[gi][BYTE_W-1:0]        = lowSlot[gi];
        if (highDirty[gi]) mergedView[gi][2*BYTE_W-1:BYTE_W] = highSlot[gi];
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          baseReg[gi]   <= '0;
          lowSlot[gi]   <= '0;
          highSlot[gi]  <= '0;
          lowDirty[gi]  <= 1'b0;
          highDirty[gi] <= 1'b0;
        end else if (hitCommit) begin
          baseReg[gi]   <= mergedView[gi];
          lowDirty[gi]  <= 1'b0;
          highDirty[gi] <= 1'b0;
        end else if (hitWrite) begin
          unique case (accessSize_e'(wrSize))
            SZ_FULL: begin
              baseReg[gi]   <= wrData;
              lowDirty[gi]  <= 1'b0;
              highDirty[gi] <= 1'b0;
            end
            SZ_LOW_WORD: begin
              baseReg[gi]   <= DATA_W'(wrData[WORD_W-1:0]);
              lowDirty[gi]  <= 1'b0;
              highDirty[gi] <= 1'b0;
            end
            SZ_LOW_BYTE: begin
              lowSlot[gi]  <= wrData[BYTE_W-1:0];
              lowDirty[gi] <= 1'b1;
            end
            SZ_SECOND_BYTE: begin
              highSlot[gi]  <= wrData[BYTE_W-1:0];
              highDirty[gi] <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  endgenerate

  assign needsMerge = lowDirty[rdAddr] || highDirty[rdAddr];

  logic [ADDR_W-1:0] selAddr;
  logic [1:0]        selSize;
  logic [DATA_W-1:0] selView;
  logic [DATA_W-1:0] shaped;

  always_comb begin
    selAddr = strobes.mergeCommit ? commitAddr : rdAddr;
    selSize = strobes.mergeCommit ? commitSize : rdSize;
    selView = mergedView[selAddr];
    unique case (accessSize_e'(selSize))
      SZ_LOW_BYTE:    shaped = DATA_W'(selView[BYTE_W-1:0]);
      SZ_SECOND_BYTE: shaped = DATA_W'(selView[2*BYTE_W-1:BYTE_W]);
      SZ_LOW_WORD:    shaped = DATA_W'(selView[WORD_W-1:0]);
      SZ_FULL:        shaped = selView;
      default:        shaped = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                                         rdData <= '0;
    else if (strobes.readNow || strobes.mergeCommit) rdData <= shaped;
  end

  AST_WORD_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrAccept && wrSize == 2'b10)
      |=> (baseReg[$past(wrAddr)][DATA_W-1:WORD_W] == '0)); // R2
  AST_WIDE_CLEARS_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrAccept && wrSize[1])
      |=> (!lowDirty[$past(wrAddr)] && !highDirty[$past(wrAddr)])); // R7
  AST_BYTE_KEEPS_BASE: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrAccept && !wrSize[1] && !strobes.mergeCommit)
      |=> (baseReg[$past(wrAddr)] == $past(baseReg[wrAddr]))); // R3
  AST_COMMIT_UNSPLITS: assert property (@(posedge clk) disable iff (rst)
    strobes.mergeCommit
      |=> (!lowDirty[$past(commitAddr)] && !highDirty[$past(commitAddr)])); // R6

endmodule

// File: rtl/prw_merge_tracker.sv
module prw_merge_tracker
  import prw_pkg::*;
#(
  parameter int NUM_REGS     = 8,
  parameter int DATA_W       = 64,
  parameter int MERGE_CYCLES = 2,
  localparam int ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrSize,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [1:0]        rdSize,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              stall
);

  ctlStrobes_t       strobes;
  logic [ADDR_W-1:0] commitAddr;
  logic [1:0]        commitSize;
  logic              needsMerge;

  prw_control #(
    .NUM_REGS    (NUM_REGS),
    .MERGE_CYCLES(MERGE_CYCLES)
  ) uCtl (
    .clk       (clk),
    .rst       (rst),
    .rdReq     (rdReq),
    .rdAddr    (rdAddr),
    .rdSize    (rdSize),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .needsMerge(needsMerge),
    .strobes   (strobes),
    .commitAddr(commitAddr),
    .commitSize(commitSize),
    .stall     (stall),
    .rdValid   (rdValid)
  );

  prw_datapath #(
    .NUM_REGS(NUM_REGS),
    .DATA_W  (DATA_W)
  ) uData (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .wrAddr    (wrAddr),
    .wrSize    (wrSize),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdSize    (rdSize),
    .commitAddr(commitAddr),
    .commitSize(commitSize),
    .needsMerge(needsMerge),
    .rdData    (rdData)
  );

endmodule

// File: tb/tb_prw_merge_tracker.sv
`timescale 1ns/1ps
module tb_prw_merge_tracker;

  localparam int MC = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn;
  logic [2:0]  wrAddr;
  logic [1:0]  wrSize;
  logic [63:0] wrData;
  logic        rdReq;
  logic [2:0]  rdAddr;
  logic [1:0]  rdSize;
  logic [63:0] rdData;
  logic        rdValid;
  logic        stall;

  int compared   = 0;
  int mismatched = 0;
  int cycles     = 0;

  logic [63:0] modelVal   [8];
  logic        modelSplit [8];

  always #4 clk = ~clk;

  prw_merge_tracker #(.MERGE_CYCLES(MC)) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrSize(wrSize),
    .wrData(wrData), .rdReq(rdReq), .rdAddr(rdAddr), .rdSize(rdSize),
    .rdData(rdData), .rdValid(rdValid), .stall(stall)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared = compared + 1;
    if (!ok) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expectRead(input int a, input logic [1:0] sz);
    case (sz)
      2'b00:   return {56'b0, modelVal[a][7:0]};
      2'b01:   return {56'b0, modelVal[a][15:8]};
      2'b10:   return {32'b0, modelVal[a][31:0]};
      default: return modelVal[a];
    endcase
  endfunction

  task automatic modelWrite(input int a, input logic [1:0] sz, input logic [63:0] d);
    case (sz)
      2'b11: begin modelVal[a] = d; modelSplit[a] = 1'b0; end
      2'b10: begin modelVal[a] = {32'b0, d[31:0]}; modelSplit[a] = 1'b0; end
      2'b00: begin modelVal[a][7:0] = d[7:0]; modelSplit[a] = 1'b1; end
      default: begin modelVal[a][15:8] = d[7:0]; modelSplit[a] = 1'b1; end
    endcase
  endtask

  task automatic writeReg(input int a, input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrSize = sz; wrData = d;
    modelWrite(a, sz, d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Issue a read, count stall cycles, then check valid and data.
  task automatic readReg(input int a, input logic [1:0] sz, input string tag);
    int n;
    int expStall;
    logic [63:0] exp;
    expStall = (sz[1] && modelSplit[a]) ? MC : 0;
    exp = expectRead(a, sz);
    @(negedge clk);
    rdReq = 1'b1; rdAddr = 3'(a); rdSize = sz;
    @(negedge clk);
    rdReq = 1'b0;
    n = 0;
    while (stall === 1'b1 && n < 50) begin
      check(rdValid === 1'b0, {tag, " valid during stall"}, 64'(rdValid), 64'd0);
      n++;
      @(negedge clk);
    end
    check(n == expStall, {tag, " stall length"}, 64'(n), 64'(expStall));
    check(rdValid === 1'b1, {tag, " rdValid"}, 64'(rdValid), 64'd1);
    check(rdData === exp, {tag, " data"}, rdData, exp);
    if (sz[1]) modelSplit[a] = 1'b0;
  endtask

  task automatic testReset();
    rst = 1'b1; wrEn = 1'b0; rdReq = 1'b0;
    wrAddr = '0; wrSize = '0; wrData = '0; rdAddr = '0; rdSize = '0;
    for (int i = 0; i < 8; i++) begin modelVal[i] = '0; modelSplit[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(stall === 1'b0, "R10 stall after reset", 64'(stall), 64'd0);
    check(rdValid === 1'b0, "R10 rdValid after reset", 64'(rdValid), 64'd0);
    for (int i = 0; i < 8; i++) readReg(i, 2'b11, "R10 reset value");
  endtask

  task automatic testFullAndWord();
    writeReg(1, 2'b11, 64'hDEAD_BEEF_CAFE_F00D);
    readReg(1, 2'b11, "R1 full write/read");
    readReg(1, 2'b10, "R2 low word read");
    writeReg(1, 2'b10, 64'hFFFF_FFFF_1234_5678);
    readReg(1, 2'b11, "R2 zero fill upper half");
    writeReg(2, 2'b11, 64'hA5A5_A5A5_A5A5_A5A5);
    readReg(2, 2'b11, "R10 clean wide read no stall");
  endtask

  task automatic testByteWrites();
    writeReg(3, 2'b11, 64'h1122_3344_5566_7788);
    writeReg(3, 2'b00, 64'h0000_0000_0000_00AB);
    writeReg(3, 2'b01, 64'h0000_0000_0000_00CD);
    readReg(3, 2'b00, "R4 low byte from slot");
    readReg(3, 2'b01, "R4 second byte from slot");
    readReg(3, 2'b11, "R3 R5 merged value after byte writes");
    readReg(3, 2'b11, "R6 no stall after merge");
    writeReg(4, 2'b11, 64'h0102_0304_0506_0708);
    writeReg(4, 2'b01, 64'h0000_0000_0000_00EE);
    readReg(4, 2'b00, "R4 low byte from base while split");
    readReg(4, 2'b10, "R3 R5 low word merge");
  endtask

  task automatic testWideClearsSplit();
    writeReg(5, 2'b00, 64'h11);
    writeReg(5, 2'b01, 64'h22);
    writeReg(5, 2'b10, 64'h0BAD_0000_7777_8888);
    readReg(5, 2'b11, "R7 word write clears split");
    writeReg(5, 2'b00, 64'h33);
    writeReg(5, 2'b11, 64'h9999_AAAA_BBBB_CCCC);
    readReg(5, 2'b11, "R7 full write clears split");
  endtask

  task automatic testMergeTraffic();
    int n;
    logic [63:0] exp;
    writeReg(6, 2'b11, 64'h0F0F_0F0F_0F0F_0F0F);
    writeReg(6, 2'b00, 64'h5A);
    writeReg(7, 2'b11, 64'h0);
    exp = modelVal[6];
    @(negedge clk);
    rdReq = 1'b1; rdAddr = 3'd6; rdSize = 2'b11;
    @(negedge clk);
    n = 0;
    while (stall === 1'b1 && n < 50) begin
      if (n == 0) begin
        wrEn = 1'b1; wrAddr = 3'd6; wrSize = 2'b11; wrData = 64'hFFFF_FFFF_FFFF_FFFF;
        rdReq = 1'b1; rdAddr = 3'd7; rdSize = 2'b00;
      end else if (n == 1) begin
        rdReq = 1'b0;
        wrEn = 1'b1; wrAddr = 3'd7; wrSize = 2'b11; wrData = 64'h7777_0000_7777_0000;
        modelWrite(7, 2'b11, 64'h7777_0000_7777_0000);
      end
      n++;
      @(negedge clk);
    end
    wrEn = 1'b0; rdReq = 1'b0;
    modelSplit[6] = 1'b0;
    check(n == MC, "R5 stall length under traffic", 64'(n), 64'(MC));
    check(rdValid === 1'b1, "R5 rdValid after stall", 64'(rdValid), 64'd1);
    check(rdData === exp, "R8 merged data unaffected by held write", rdData, exp);
    @(negedge clk);
    check(rdValid === 1'b0, "R9 read during stall ignored", 64'(rdValid), 64'd0);
    readReg(6, 2'b11, "R8 write to merging register dropped");
    readReg(7, 2'b11, "R8 write to other register applied");
  endtask

  initial begin
    testReset();
    testFullAndWord();
    testByteWrites();
    testWideClearsSplit();
    testMergeTraffic();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule